// File: doc/BRIEF.md
# Frame Interrupt Control Register Window

This block is the control side of a framebuffer controller: a 32-byte register window on a byte-wide bus. Software uses it to turn on an interrupt that fires once per displayed frame, to see whether that interrupt is outstanding, and to acknowledge it. The display timing logic supplies a one-cycle frame-end strobe, and the block drives a level-sensitive interrupt line that stays high until software acknowledges it.

The status byte combines one dynamic bit, the sticky pending flag, with fixed identification bits that give the monitor type and mark the board as a colour board. The upper half of the window also holds a control byte and fourteen general-purpose byte registers that simply store what is written. The lower half of the window is decoded by a neighbouring palette block, so here it reads as zero and writes to it have no effect. Reads have no side effects, and read data follows the address in the same cycle.

Top module: `fbc_ctl_regs`

## Requirements
- R1: While reset is asserted and right after it is released, the interrupt is low, the control byte and all general-purpose bytes read 0x00, and the status byte reads 0x61.
- R2: The control byte at offset 0x10 is written in full by a bus write and reads back the last value written.
- R3: A read of the status byte at offset 0x11 returns the pending flag in bit 7, the monitor-type bits 6:5 set, bits 4:1 clear, and the colour-board bit 0 set. The value is 0xE1 when the flag is set and 0x61 when it is clear.
- R4: A frame-end strobe sampled while control bit 7 is 1 sets the pending flag, and the interrupt is high from the next clock edge.
- R5: A frame-end strobe sampled while control bit 7 is 0 does not change the pending flag or the interrupt.
- R6: A bus write to offset 0x11 clears the pending flag, and the interrupt is low after that edge, whatever the write data is.
- R7: When a frame-end strobe with control bit 7 set and a write to offset 0x11 fall on the same edge, the pending flag ends up set and the interrupt stays high.
- R8: Offsets 0x12 through 0x1F are independent byte registers that each read back the last value written to them.
- R9: Offsets 0x00 through 0x0F read as 0x00, and writes to them change no register in the window and do not change the interrupt.
- R10: The pending flag is sticky. Clearing control bit 7 or receiving further frame-end strobes does not clear it. Only a write to offset 0x11 or reset clears it.
- R11: The interrupt output always equals bit 7 of the status read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed byte |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| frame_end | input | 1 | One-cycle end-of-frame strobe from display timing |
| irq | output | 1 | Level interrupt; high while the pending flag is set |

## Verification
The frame interrupt is exercised with frame-end strobes under each value of the enable bit. These cases separate a flag that follows the enable correctly from one that ignores it or drops when the enable is cleared. Acknowledge writes are sent with all-zero and all-one data, both while the flag is set and while it is clear. A strobe and an acknowledge are also placed on the same edge, which shows whether set or clear has priority. Writes to every general-purpose byte and to the whole lower half of the window check that each address reaches only its own register. A long pseudo-random mix of writes, reads and strobes follows, and every cycle of it is compared against a behavioural model.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  typedef enum logic [1:0] {
    FBC_RGN_NONE = 2'd0,
    FBC_RGN_CTRL = 2'd1,
    FBC_RGN_STAT = 2'd2,
    FBC_RGN_GP   = 2'd3
  } fbc_region_e;

  localparam int unsigned FBC_ADDR_W     = 5;
  localparam int unsigned FBC_DATA_W     = 8;
  localparam int unsigned FBC_IRQ_EN_BIT = 7;
  localparam int unsigned FBC_PEND_BIT   = 7;
  localparam logic [7:0]  FBC_STATUS_ID  = 8'h61;

endpackage

// File: rtl/fbc_addr_dec.sv
module fbc_addr_dec
  import fbc_pkg::*;
#(
  parameter int unsigned ADDR_W = FBC_ADDR_W,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output fbc_region_e       region,
  output logic [IDX_W-1:0]  gp_idx
);

  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(1 << (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] STAT_OFF = CTRL_OFF + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] GP_BASE  = CTRL_OFF + ADDR_W'(2);

  function automatic fbc_region_e region_of(input logic [ADDR_W-1:0] a);
    if (a == CTRL_OFF)      return FBC_RGN_CTRL;
    else if (a == STAT_OFF) return FBC_RGN_STAT;
    else if (a >= GP_BASE)  return FBC_RGN_GP;
    else                    return FBC_RGN_NONE;
  endfunction

  function automatic logic [IDX_W-1:0] gp_index_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] d;
    d = a - GP_BASE;
    return d[IDX_W-1:0];
  endfunction

  assign region = region_of(addr);
  assign gp_idx = gp_index_of(addr);

endmodule

// File: rtl/fbc_gp_bank.sv
module fbc_gp_bank
  import fbc_pkg::*;
#(
  parameter int unsigned DATA_W = FBC_DATA_W,
  parameter int unsigned NUM_GP = 14,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_GP-1:0][DATA_W-1:0] bank;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_byte
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && idx == IDX_W'(g))     q <= wdata;
    end
    assign bank[g] = q;
  end

  always_comb begin
    rdata = '0;
    if (idx < IDX_W'(NUM_GP)) rdata = bank[idx];
  end

endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic irq_en,
  input  logic ack,
  output logic set_evt,
  output logic ack_evt,
  output logic pending
);

  function automatic logic next_pending(input logic cur, input logic set,
                                        input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  assign set_evt = frame_end & irq_en;
  assign ack_evt = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= next_pending(pending, set_evt, ack_evt);
  end

endmodule

// File: rtl/fbc_ctl_regs.sv
module fbc_ctl_regs
  import fbc_pkg::*;
#(
  parameter int unsigned ADDR_W     = FBC_ADDR_W,
  parameter int unsigned DATA_W     = FBC_DATA_W,
  parameter int unsigned IRQ_EN_BIT = FBC_IRQ_EN_BIT,
  parameter int unsigned PEND_BIT   = FBC_PEND_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_end,
  output logic              irq
);

  localparam int unsigned WIN_BYTES = 1 << ADDR_W;
  localparam int unsigned NUM_GP    = WIN_BYTES / 2 - 2;
  localparam int unsigned IDX_W     = $clog2(NUM_GP);

  fbc_region_e       region;
  logic [IDX_W-1:0]  gp_idx;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] gp_rdata;
  logic              irq_en;
  logic              set_evt;
  logic              ack_evt;
  logic              pending;

  function automatic logic [DATA_W-1:0] status_view(input logic pend);
    logic [DATA_W-1:0] v;
    v = DATA_W'(FBC_STATUS_ID);
    v[PEND_BIT] = pend;
    return v;
  endfunction

  fbc_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr   (bus_addr),
    .region (region),
    .gp_idx (gp_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ctrl_q <= '0;
    else if (bus_we && region == FBC_RGN_CTRL) ctrl_q <= bus_wdata;
  end

  assign irq_en = ctrl_q[IRQ_EN_BIT];

  fbc_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .irq_en    (irq_en),
    .ack       (bus_we && region == FBC_RGN_STAT),
    .set_evt   (set_evt),
    .ack_evt   (ack_evt),
    .pending   (pending)
  );

  fbc_gp_bank #(.DATA_W(DATA_W), .NUM_GP(NUM_GP), .IDX_W(IDX_W)) u_gp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we && region == FBC_RGN_GP),
    .idx   (gp_idx),
    .wdata (bus_wdata),
    .rdata (gp_rdata)
  );

  always_comb begin
    unique case (region)
      FBC_RGN_CTRL: bus_rdata = ctrl_q;
      FBC_RGN_STAT: bus_rdata = status_view(pending);
      FBC_RGN_GP:   bus_rdata = gp_rdata;
      default:      bus_rdata = '0;
    endcase
  end

  assign irq = pending;

endmodule

// File: rtl/fbc_ctl_regs_chk.sv
module fbc_ctl_regs_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              frame_end,
  input logic              irq_en,
  input logic              set_evt,
  input logic              ack_evt,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'((1 << (ADDR_W - 1)) + 1);

  AST_FRAME_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && irq_en) |=> irq); // R4

  AST_NO_EN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !(bus_we && bus_addr == STAT_A)) |=> $stable(irq)); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !set_evt) |=> !irq); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && set_evt) |=> irq); // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_evt) |=> irq); // R10

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_A) |-> (bus_rdata[DATA_W-1] == irq)); // R11

  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1] == 1'b0) |-> (bus_rdata == '0)); // R9

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (irq == 1'b0); // R1
    end
  end

endmodule

bind fbc_ctl_regs fbc_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .frame_end (frame_end),
  .irq_en    (irq_en),
  .set_evt   (set_evt),
  .ack_evt   (ack_evt),
  .irq       (irq)
);

// File: tb/fbc_ctl_regs_bench.sv
`timescale 1ns/1ps
module fbc_ctl_regs_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       frame_end = 1'b0;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int m_mem[32];
  int m_pend = 0;

  always #2 clk = ~clk;

  fbc_ctl_regs u_fbc_ctl_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .frame_end (frame_end),
    .irq       (irq)
  );

  function automatic int model_read(input int a);
    if (a < 16)  return 0;
    if (a == 17) return (m_pend ? 128 : 0) + 'h61;
    return m_mem[a];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    m_pend = 0;
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle: inputs set after negedge, outputs compared, then edge
  task automatic step(input bit we, input int a, input int d, input bit fe,
                      input string tag);
    bus_we = we; bus_addr = a[4:0]; bus_wdata = d[7:0]; frame_end = fe;
    #1;
    check(tag, int'(bus_rdata), model_read(a), "rdata");
    check(tag, int'(irq), m_pend, "irq");
    @(posedge clk);
    if (rst_n) begin
      int np;
      np = m_pend;
      if (we && a == 17) np = 0;
      if (fe && m_mem[16] >= 128) np = 1;
      if (we && (a == 16 || a >= 18)) m_mem[a] = d & 255;
      m_pend = np;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lfsr;
    model_reset();
    @(negedge clk);
    // R1: reset state
    step(1'b0, 17, 0, 1'b0, "R1");
    step(1'b1, 16, 'hFF, 1'b1, "R1");
    step(1'b0, 16, 0, 1'b0, "R1");
    step(1'b0, 21, 0, 1'b0, "R1");
    rst_n = 1'b1;
    step(1'b0, 17, 0, 1'b0, "R1");
    step(1'b0, 31, 0, 1'b0, "R1");

    // R2: control byte
    step(1'b1, 16, 'h5A, 1'b0, "R2");
    step(1'b0, 16, 0, 1'b0, "R2");

    // R8: general purpose bytes
    for (int i = 18; i < 32; i++) step(1'b1, i, 'hA0 + i, 1'b0, "R8");
    for (int i = 18; i < 32; i++) step(1'b0, i, 0, 1'b0, "R8");

    // R9: lower half reads zero, writes ignored
    for (int i = 0; i < 16; i++) step(1'b1, i, 'hFF, 1'b0, "R9");
    for (int i = 0; i < 16; i++) step(1'b0, i, 0, 1'b0, "R9");
    step(1'b0, 16, 0, 1'b0, "R9");
    for (int i = 18; i < 32; i++) step(1'b0, i, 0, 1'b0, "R9");

    // R5: strobe with enable clear
    step(1'b0, 17, 0, 1'b1, "R5");
    step(1'b0, 17, 0, 1'b0, "R5");

    // R4 / R3: enable and strobe
    step(1'b1, 16, 'h80, 1'b0, "R4");
    step(1'b0, 17, 0, 1'b1, "R4");
    step(1'b0, 17, 0, 1'b0, "R3");

    // R10: sticky across enable clear and more strobes
    step(1'b1, 16, 'h00, 1'b0, "R10");
    step(1'b0, 17, 0, 1'b1, "R10");
    step(1'b1, 16, 'h80, 1'b1, "R10");
    step(1'b0, 17, 0, 1'b0, "R10");

    // R6: acknowledge, data independent
    step(1'b1, 17, 'h00, 1'b0, "R6");
    step(1'b0, 17, 0, 1'b0, "R6");
    step(1'b0, 17, 0, 1'b1, "R6");
    step(1'b1, 17, 'hFF, 1'b0, "R6");
    step(1'b1, 17, 'h80, 1'b0, "R6");
    step(1'b0, 17, 0, 1'b0, "R6");

    // R7: simultaneous set and acknowledge
    step(1'b1, 17, 'hFF, 1'b1, "R7");
    step(1'b0, 17, 0, 1'b0, "R7");
    step(1'b1, 17, 0, 1'b0, "R7");
    step(1'b0, 17, 0, 1'b0, "R7");

    // R11 / mixed traffic
    lfsr = 'hACE1;
    for (int n = 0; n < 3000; n++) begin
      bit we, fe;
      int a, d;
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
      we = lfsr[0];
      fe = lfsr[3] & lfsr[5];
      a  = (lfsr >> 6) & 31;
      if (lfsr[13]) a = 16 + ((lfsr >> 11) & 1);
      d  = (lfsr >> 4) & 255;
      step(we, a, d, fe, "R11");
    end

    finish_run();
  end

endmodule